// File: doc/BRIEF.md
# I2C Slave Write Receiver with Acknowledge Hold

This block is the receive side of a 7-bit-addressed I2C target for transfers in which the controller writes. It samples the bus clock and data lines with the system clock, recognises start and stop conditions, and compares the first byte after a start with its own address. It then shifts in data bytes, drives the acknowledge bit, and can hold the bus clock low until the host software is ready.

A host-side register interface presents the last accepted byte, a full flag, an overrun flag, an interrupt flag and several status bits. The host can take part in each acknowledge decision. When the address-pause or data-pause option is on, the block stops after the eighth falling clock edge and raises the interrupt. The host then supplies the acknowledge value and releases the clock. A status bit tells the host whether the pending interrupt came before or after the acknowledge slot.

Both bus lines are handled as open-drain: the block only ever asserts pull-low enables.

Top module: `i2c_hold_rx`

## Requirements
- R1: After reset both pull-low enables are 0, the full, overrun and interrupt flags are 0, and the clock-release bit `clk_rel` reads 1.
- R2: A start condition (SDA falling while SCL is high) sets `st_start`, clears `st_stop`, and sets `irq` only when `cfg_start_irq` is 1.
- R3: A stop condition (SDA rising while SCL is high) sets `st_stop`, clears `st_start`, and sets `irq` only when `cfg_stop_irq` is 1.
- R4: An address byte whose upper 7 bits equal `cfg_addr` and whose bit 0 (R/W) is 0 is acknowledged by pulling SDA low in the 9th clock. The byte is loaded into `rx_byte`, `rx_full` is set, and `st_rw` and `st_data` read 0.
- R5: An address byte that differs from `cfg_addr`, or that has bit 0 set, gets no SDA drive and no interrupt. Every later byte is ignored until the next start.
- R6: Each data byte of a matched transfer is loaded into `rx_byte` with `st_data`=1 and is acknowledged. `irq` is set after the 9th falling SCL edge whenever an ACK was sent, and a `host_rd` pulse clears `rx_full`.
- R7: With `cfg_stretch`=1, SCL is held low after the 9th falling edge of an acknowledged byte, with `clk_rel`=0, until the host pulses `host_release`.
- R8: With `cfg_addr_hold` (address byte) or `cfg_data_hold` (data byte) set, the 8th falling SCL edge sets `irq` and `st_acktim`, clears `clk_rel` and holds SCL low. On `host_release` the block drives `host_ack_nack` (0 = ACK, 1 = NACK) in the 9th clock, and `st_acktim` returns to 0 at the 9th falling edge.
- R9: When the host answers NACK in hold mode, no interrupt is raised at the 9th edge and the block ignores the bus until the next start.
- R10: When a byte completes while `rx_full` or `rx_ovf` is set and `cfg_ovr_en` is 0, the block answers NACK, keeps `rx_byte` unchanged and sets `rx_ovf` if `rx_full` was set.
- R11: With `cfg_ovr_en`=1, a byte that completes while `rx_full` is set is still loaded and acknowledged, and `rx_ovf` is set.
- R12: The block never asserts both pull-low enables at the same time, and SCL is held only while `clk_rel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| scl_pull | output | 1 | Pull SCL low (clock hold) |
| sda_pull | output | 1 | Pull SDA low (acknowledge) |
| cfg_addr | input | 7 | Own 7-bit address |
| cfg_addr_hold | input | 1 | Pause for a host decision after an address byte |
| cfg_data_hold | input | 1 | Pause for a host decision after a data byte |
| cfg_stretch | input | 1 | Hold SCL after each acknowledged byte |
| cfg_start_irq | input | 1 | Interrupt on start condition |
| cfg_stop_irq | input | 1 | Interrupt on stop condition |
| cfg_ovr_en | input | 1 | Accept bytes even when the buffer is full |
| host_ack_nack | input | 1 | Acknowledge value for hold mode, 0 = ACK |
| host_release | input | 1 | Strobe that sets `clk_rel` and lets SCL go |
| host_rd | input | 1 | Strobe that marks the buffer as read |
| host_irq_clr | input | 1 | Strobe that clears `irq` |
| host_ovf_clr | input | 1 | Strobe that clears `rx_ovf` |
| rx_byte | output | 8 | Last accepted byte |
| rx_full | output | 1 | Buffer holds an unread byte |
| rx_ovf | output | 1 | A byte arrived while the buffer was full |
| irq | output | 1 | Interrupt flag |
| st_start | output | 1 | Last condition seen was a start |
| st_stop | output | 1 | Last condition seen was a stop |
| st_rw | output | 1 | R/W bit of the last matched address |
| st_data | output | 1 | Last loaded byte was data (1) or address (0) |
| st_acktim | output | 1 | Pending interrupt came before the acknowledge slot |
| clk_rel | output | 1 | Clock-release bit, 0 while the block holds SCL |

## Verification
Two things can happen in the same system-clock cycle. A byte can complete on the 8th falling edge in the very cycle the host strobes `host_rd` or `host_irq_clr`, and in that case the set must win over the clear. A host release can also land while the pause state is being entered. The bench provokes the first case with host strobes that run alongside the controller model in hold mode. It also uses randomly sized transfers in which the host read trails each interrupt by only a few cycles. Each case is judged at the ports: the acknowledge level seen on SDA in the 9th clock, and the `rx_full`, `irq` and `rx_byte` values that follow.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for a start
    ST_SHIFT,  // collecting bits of a byte
    ST_HOLD8,  // paused after 8th falling edge, host decides
    ST_ACK,    // driving the acknowledge slot
    ST_HOLD9   // paused after 9th falling edge
  } rx_state_e;
endpackage

// File: rtl/i2c_rx_sync.sv
module i2c_rx_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] level,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] fall
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-1:0], din[g]};
    end
    assign level[g] = chain[STAGES-1];
    assign rise[g]  = chain[STAGES-1] & ~chain[STAGES];
    assign fall[g]  = ~chain[STAGES-1] & chain[STAGES];
  end
endmodule

// File: rtl/i2c_rx_cond.sv
module i2c_rx_cond (
  input  logic scl_level,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic start_det,
  output logic stop_det
);
  always_comb begin
    start_det = sda_fall & scl_level;
    stop_det  = sda_rise & scl_level;
  end
endmodule

// File: rtl/i2c_rx_core.sv
module i2c_rx_core
  import i2c_rx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_level,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-2:0] cfg_addr,
  input  logic              cfg_addr_hold,
  input  logic              cfg_data_hold,
  input  logic              cfg_stretch,
  input  logic              cfg_start_irq,
  input  logic              cfg_stop_irq,
  input  logic              cfg_ovr_en,
  input  logic              host_ack_nack,
  input  logic              host_release,
  input  logic              host_rd,
  input  logic              host_irq_clr,
  input  logic              host_ovf_clr,
  output logic              scl_pull,
  output logic              sda_pull,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_full,
  output logic              rx_ovf,
  output logic              irq,
  output logic              st_start,
  output logic              st_stop,
  output logic              st_rw,
  output logic              st_data,
  output logic              st_acktim,
  output logic              clk_rel
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  rx_state_e         state;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic              in_data;
  logic              ack_nack;

  logic addr_ok, blocked, pause_here, byte_end;

  always_comb begin
    addr_ok    = (shreg[BYTE_W-1:1] == cfg_addr) && !shreg[0];
    blocked    = (rx_full || rx_ovf) && !cfg_ovr_en;
    pause_here = in_data ? cfg_data_hold : cfg_addr_hold;
    byte_end   = scl_fall && (bit_cnt == LAST_BIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      shreg     <= '0;
      bit_cnt   <= '0;
      in_data   <= 1'b0;
      ack_nack  <= 1'b1;
      scl_pull  <= 1'b0;
      sda_pull  <= 1'b0;
      rx_byte   <= '0;
      rx_full   <= 1'b0;
      rx_ovf    <= 1'b0;
      irq       <= 1'b0;
      st_start  <= 1'b0;
      st_stop   <= 1'b0;
      st_rw     <= 1'b0;
      st_data   <= 1'b0;
      st_acktim <= 1'b0;
      clk_rel   <= 1'b1;
    end else begin
      // host side clears; block-side sets below take priority
      if (host_rd)      rx_full <= 1'b0;
      if (host_irq_clr) irq     <= 1'b0;
      if (host_ovf_clr) rx_ovf  <= 1'b0;
      if (host_release) clk_rel <= 1'b1;

      if (start_det) begin
        st_start <= 1'b1;
        st_stop  <= 1'b0;
        state    <= ST_SHIFT;
        bit_cnt  <= '0;
        in_data  <= 1'b0;
        sda_pull <= 1'b0;
        scl_pull <= 1'b0;
        if (cfg_start_irq) irq <= 1'b1;
      end else if (stop_det) begin
        st_stop  <= 1'b1;
        st_start <= 1'b0;
        state    <= ST_IDLE;
        sda_pull <= 1'b0;
        scl_pull <= 1'b0;
        if (cfg_stop_irq) irq <= 1'b1;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_SHIFT: begin
            if (scl_rise && bit_cnt != LAST_BIT) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_level};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (byte_end) begin
              if (!in_data && !addr_ok) begin
                state <= ST_IDLE;
              end else begin
                if (rx_full) rx_ovf <= 1'b1;
                if (blocked) begin
                  ack_nack <= 1'b1;
                  state    <= ST_ACK;
                end else begin
                  rx_byte <= shreg;
                  rx_full <= 1'b1;
                  st_data <= in_data;
                  if (!in_data) st_rw <= shreg[0];
                  if (pause_here) begin
                    irq       <= 1'b1;
                    st_acktim <= 1'b1;
                    clk_rel   <= 1'b0;
                    scl_pull  <= 1'b1;
                    state     <= ST_HOLD8;
                  end else begin
                    ack_nack <= 1'b0;
                    sda_pull <= 1'b1;
                    state    <= ST_ACK;
                  end
                end
              end
            end
          end
          ST_HOLD8: begin
            if (host_release) begin
              ack_nack <= host_ack_nack;
              sda_pull <= !host_ack_nack;
              scl_pull <= 1'b0;
              state    <= ST_ACK;
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              sda_pull  <= 1'b0;
              st_acktim <= 1'b0;
              if (!ack_nack) begin
                irq <= 1'b1;
                if (cfg_stretch) begin
                  clk_rel  <= 1'b0;
                  scl_pull <= 1'b1;
                  state    <= ST_HOLD9;
                end else begin
                  state   <= ST_SHIFT;
                  bit_cnt <= '0;
                  in_data <= 1'b1;
                end
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_HOLD9: begin
            if (host_release) begin
              scl_pull <= 1'b0;
              state    <= ST_SHIFT;
              bit_cnt  <= '0;
              in_data  <= 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_hold_rx.sv
module i2c_hold_rx #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull,
  output logic              sda_pull,
  input  logic [BYTE_W-2:0] cfg_addr,
  input  logic              cfg_addr_hold,
  input  logic              cfg_data_hold,
  input  logic              cfg_stretch,
  input  logic              cfg_start_irq,
  input  logic              cfg_stop_irq,
  input  logic              cfg_ovr_en,
  input  logic              host_ack_nack,
  input  logic              host_release,
  input  logic              host_rd,
  input  logic              host_irq_clr,
  input  logic              host_ovf_clr,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_full,
  output logic              rx_ovf,
  output logic              irq,
  output logic              st_start,
  output logic              st_stop,
  output logic              st_rw,
  output logic              st_data,
  output logic              st_acktim,
  output logic              clk_rel
);
  localparam int SCL_IDX = 0;
  localparam int SDA_IDX = 1;

  logic [1:0] lvl, rse, fll;
  logic       start_det, stop_det;

  i2c_rx_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk(clk), .rst(rst), .din({sda_i, scl_i}),
    .level(lvl), .rise(rse), .fall(fll)
  );

  i2c_rx_cond u_cond (
    .scl_level(lvl[SCL_IDX]), .sda_rise(rse[SDA_IDX]), .sda_fall(fll[SDA_IDX]),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_rx_core #(.BYTE_W(BYTE_W)) u_core (
    .clk(clk), .rst(rst),
    .scl_rise(rse[SCL_IDX]), .scl_fall(fll[SCL_IDX]), .sda_level(lvl[SDA_IDX]),
    .start_det(start_det), .stop_det(stop_det),
    .cfg_addr(cfg_addr), .cfg_addr_hold(cfg_addr_hold), .cfg_data_hold(cfg_data_hold),
    .cfg_stretch(cfg_stretch), .cfg_start_irq(cfg_start_irq), .cfg_stop_irq(cfg_stop_irq),
    .cfg_ovr_en(cfg_ovr_en), .host_ack_nack(host_ack_nack), .host_release(host_release),
    .host_rd(host_rd), .host_irq_clr(host_irq_clr), .host_ovf_clr(host_ovf_clr),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .rx_byte(rx_byte), .rx_full(rx_full),
    .rx_ovf(rx_ovf), .irq(irq), .st_start(st_start), .st_stop(st_stop), .st_rw(st_rw),
    .st_data(st_data), .st_acktim(st_acktim), .clk_rel(clk_rel)
  );
endmodule

// File: rtl/i2c_hold_rx_chk.sv
module i2c_hold_rx_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_pull,
  input logic              sda_pull,
  input logic              clk_rel,
  input logic              irq,
  input logic              st_acktim,
  input logic              st_start,
  input logic              st_stop,
  input logic [BYTE_W-1:0] rx_byte,
  input logic              rx_full
);
  assert_no_dual_pull_R12: assert property (@(posedge clk) disable iff (rst)
    !(scl_pull && sda_pull));

  assert_hold_needs_release_low_R12: assert property (@(posedge clk) disable iff (rst)
    scl_pull |-> !clk_rel);

  assert_pause_holds_clock_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_rel) |-> scl_pull);

  assert_acktim_with_irq_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(st_acktim) |-> irq);

  assert_start_stop_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(st_start && st_stop));

  assert_load_marks_full_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_byte) |-> rx_full);
endmodule

bind i2c_hold_rx i2c_hold_rx_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .scl_pull(scl_pull), .sda_pull(sda_pull),
  .clk_rel(clk_rel), .irq(irq), .st_acktim(st_acktim), .st_start(st_start),
  .st_stop(st_stop), .rx_byte(rx_byte), .rx_full(rx_full)
);

// File: tb/i2c_hold_rx_test.sv
module i2c_hold_rx_test;
  localparam int T = 16;
  localparam logic [6:0] OWN = 7'h2C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_pull, sda_pull;
  wire  scl_line = scl_m & ~scl_pull;
  wire  sda_line = sda_m & ~sda_pull;

  logic cfg_addr_hold = 0, cfg_data_hold = 0, cfg_stretch = 0;
  logic cfg_start_irq = 0, cfg_stop_irq = 0, cfg_ovr_en = 0;
  logic host_ack_nack = 0, host_release = 0, host_rd = 0, host_irq_clr = 0, host_ovf_clr = 0;
  logic [7:0] rx_byte;
  logic rx_full, rx_ovf, irq, st_start, st_stop, st_rw, st_data, st_acktim, clk_rel;

  int total = 0, bad = 0;

  i2c_hold_rx uut (
    .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .cfg_addr(OWN),
    .cfg_addr_hold(cfg_addr_hold), .cfg_data_hold(cfg_data_hold), .cfg_stretch(cfg_stretch),
    .cfg_start_irq(cfg_start_irq), .cfg_stop_irq(cfg_stop_irq), .cfg_ovr_en(cfg_ovr_en),
    .host_ack_nack(host_ack_nack), .host_release(host_release), .host_rd(host_rd),
    .host_irq_clr(host_irq_clr), .host_ovf_clr(host_ovf_clr),
    .rx_byte(rx_byte), .rx_full(rx_full), .rx_ovf(rx_ovf), .irq(irq),
    .st_start(st_start), .st_stop(st_stop), .st_rw(st_rw), .st_data(st_data),
    .st_acktim(st_acktim), .clk_rel(clk_rel)
  );

  function automatic logic exp_ack(input logic [7:0] b);
    return (b[7:1] == OWN && !b[0]) ? 1'b0 : 1'b1;  // 0 = ACK seen on SDA
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: host_rd = 1'b1;
      1: host_irq_clr = 1'b1;
      2: host_release = 1'b1;
      default: host_ovf_clr = 1'b1;
    endcase
    @(negedge clk);
    host_rd = 0; host_irq_clr = 0; host_release = 0; host_ovf_clr = 0;
  endtask

  task automatic bus_start;
    sda_m = 1; wait_n(4); scl_m = 1; wait_n(T);
    sda_m = 0; wait_n(T);
    scl_m = 0; wait_n(T);
  endtask

  task automatic bus_stop;
    sda_m = 0; wait_n(T);
    scl_m = 1; wait (scl_line === 1'b1); wait_n(T);
    sda_m = 1; wait_n(T);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ackbit);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_n(T);
      scl_m = 1; wait (scl_line === 1'b1); wait_n(T);
      scl_m = 0; wait_n(4);
    end
    sda_m = 1; wait_n(T);
    scl_m = 1; wait (scl_line === 1'b1); wait_n(T / 2);
    ackbit = sda_line; wait_n(T / 2);
    scl_m = 0; wait_n(T);
  endtask

  task automatic host_hold(input logic [7:0] expb, input logic ackval, input string req);
    while (!irq) @(negedge clk);
    wait_n(2);
    check({req, " acktim at 8th edge"}, st_acktim, 1);
    check({req, " clk_rel cleared"}, clk_rel, 0);
    check({req, " SCL held"}, scl_pull, 1);
    check({req, " byte at 8th edge"}, rx_byte, expb);
    host_ack_nack = ackval;
    strobe(1);
    strobe(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] b, d;
    int nd;
    void'($urandom(32'd7));
    wait_n(5);
    rst = 0;
    wait_n(2);
    // R1 reset state
    check("R1 scl_pull", scl_pull, 0);
    check("R1 sda_pull", sda_pull, 0);
    check("R1 flags", {rx_full, rx_ovf, irq}, 0);
    check("R1 clk_rel", clk_rel, 1);

    // R2 / R3 start and stop flags and their interrupt enables
    cfg_start_irq = 1;
    bus_start;
    check("R2 st_start", {st_start, st_stop}, 2'b10);
    check("R2 irq on start", irq, 1);
    strobe(1);
    bus_stop;
    check("R3 st_stop", {st_start, st_stop}, 2'b01);
    check("R3 no irq when stop irq off", irq, 0);
    cfg_start_irq = 0; cfg_stop_irq = 1;
    bus_start;
    check("R2 no irq when start irq off", irq, 0);
    bus_stop;
    check("R3 irq on stop", irq, 1);
    strobe(1);
    cfg_stop_irq = 0;

    // R4 / R6 directed transfer
    bus_start;
    send_byte({OWN, 1'b0}, a);
    check("R4 address ACK", a, 0);
    check("R4 buffer holds address", rx_byte, {OWN, 1'b0});
    check("R4 full/rw/data", {rx_full, st_rw, st_data}, 3'b100);
    check("R6 irq after 9th edge", irq, 1);
    strobe(1); strobe(0);
    check("R6 read clears full", rx_full, 0);
    send_byte(8'hC3, a);
    check("R6 data ACK", a, 0);
    check("R6 data byte", {rx_byte, st_data, irq}, {8'hC3, 2'b11});
    strobe(1); strobe(0);
    bus_stop;

    // R5 mismatch, then a byte looking like own address is ignored
    bus_start;
    send_byte({OWN ^ 7'h01, 1'b0}, a);
    check("R5 mismatch NACK", a, 1);
    send_byte({OWN, 1'b0}, a);
    check("R5 later byte ignored", {a, irq, rx_full}, 3'b100);
    bus_stop;
    bus_start;
    send_byte({OWN, 1'b1}, a);
    check("R5 read request not answered", {a, irq}, 2'b10);
    bus_stop;

    // R10 overflow without overwrite
    bus_start;
    send_byte({OWN, 1'b0}, a);
    strobe(1);
    send_byte(8'h11, a);
    check("R10 NACK when full", a, 1);
    check("R10 buffer kept", rx_byte, {OWN, 1'b0});
    check("R10 ovf set, no irq", {rx_ovf, irq}, 2'b10);
    bus_stop;

    // R11 overwrite enabled
    cfg_ovr_en = 1;
    bus_start;
    send_byte({OWN, 1'b0}, a);
    check("R11 address ACK while full", a, 0);
    strobe(1);
    send_byte(8'h77, a);
    check("R11 data ACK and loaded", {a, rx_byte, rx_ovf}, {1'b0, 8'h77, 1'b1});
    strobe(1);
    bus_stop;
    cfg_ovr_en = 0;
    strobe(0); strobe(3);
    check("R10 flags cleared by host", {rx_full, rx_ovf}, 0);

    // R7 stretch after ACK
    cfg_stretch = 1;
    bus_start;
    send_byte({OWN, 1'b0}, a);
    wait_n(T);
    check("R7 SCL held after ACK", {scl_pull, scl_line, clk_rel}, 3'b100);
    strobe(1); strobe(0); strobe(2);
    wait_n(2);
    check("R7 released", {scl_pull, clk_rel}, 2'b01);
    send_byte(8'h3E, a);
    check("R7 data ACK", {a, rx_byte}, {1'b0, 8'h3E});
    strobe(1); strobe(0); strobe(2);
    bus_stop;
    cfg_stretch = 0;

    // R8 / R9 hold mode with host decision
    cfg_addr_hold = 1; cfg_data_hold = 1;
    bus_start;
    fork
      send_byte({OWN, 1'b0}, a);
      host_hold({OWN, 1'b0}, 1'b0, "R8 addr");
    join
    check("R8 host ACK driven", a, 0);
    check("R8 irq after 9th, acktim clear", {irq, st_acktim}, 2'b10);
    strobe(1); strobe(0);
    fork
      send_byte(8'h5A, d[0]);
      host_hold(8'h5A, 1'b1, "R8 data");
    join
    check("R9 host NACK driven", d[0], 1);
    check("R9 no irq after NACK", irq, 0);
    strobe(0);
    send_byte({OWN, 1'b0}, a);
    check("R9 idle after NACK", {a, irq, rx_full}, 3'b100);
    bus_stop;
    cfg_addr_hold = 0; cfg_data_hold = 0; host_ack_nack = 0;

    // random transfers
    for (int t = 0; t < 16; t++) begin
      b = ($urandom % 2) ? {OWN, 1'b0} : {7'($urandom), 1'($urandom)};
      nd = 1 + $urandom % 3;
      bus_start;
      send_byte(b, a);
      check("R4 random address ack", a, exp_ack(b));
      if (!a) begin strobe(1); strobe(0); end
      for (int k = 0; k < nd; k++) begin
        d = 8'($urandom);
        send_byte(d, a);
        check("R6 random data ack", a, exp_ack(b));
        if (exp_ack(b) == 0) begin
          check("R6 random data byte", rx_byte, d);
          strobe(1); strobe(0);
        end
      end
      bus_stop;
      check("R3 random stop flag", st_stop, 1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule